// File: doc/BRIEF.md
# Timeslot-Selectable PRBS Test Engine

This block inserts and checks a 2^15-1 pseudo-random test pattern on a bit-serial framed stream with 32 timeslots of eight bits each. Two serial paths pass through it: a transmit path and a receive path. One path carries the generated pattern and the other path is checked against it, and a direction control swaps the two roles. A single frame-sync strobe marks the first bit of timeslot 0. That strobe sets where each timeslot lies in both paths.

The pattern can cover every bit of the stream. It can also cover only the timeslots whose bit is set in a 32-bit mask, using either all eight bits of each such timeslot or only its first seven. The detector uses the previous fifteen bits it has checked to predict each new checked bit. A small state machine has three states: ST_OFF, ST_HUNT and ST_LOCK. ST_OFF moves to ST_HUNT when a test mode is selected. ST_HUNT moves to ST_LOCK after a run of clean bits. ST_LOCK moves back to ST_HUNT when too many errors arrive, and any state moves to ST_OFF when the mode returns to off. While the detector is in ST_LOCK, a saturating counter counts bit errors, and a clear pulse empties it.

Top module: `prbs_ts_engine`

## Requirements
- R1: With `mode` = 00 both paths pass through unchanged (`tx_out`=`tx_in`, `rx_out`=`rx_in`), the generator does not advance, and `in_sync` is low from the cycle after.
- R2: With `dir` = 0 the pattern replaces bits on `tx_out` and `rx_in` is checked, while `rx_out` equals `rx_in`. With `dir` = 1 the pattern replaces bits on `rx_out` and `tx_in` is checked, while `tx_out` equals `tx_in`.
- R3: The bit presented with `frame_sync` high is position 0. Positions then count up modulo 256. Timeslot n occupies positions 8n to 8n+7, its most significant bit first. A new `frame_sync` restarts the count at any point.
- R4: With `mode` = 01 (unframed) every bit is replaced and checked, and `ts_mask` has no effect.
- R5: With `mode` = 10 (8-bit) all eight bits of timeslot n are replaced and checked when `ts_mask[n]` is 1. All other bits pass through.
- R6: With `mode` = 11 (7-bit) the first seven bits of each selected timeslot are replaced and checked. The eighth bit (least significant, position 8n+7) passes through and is not checked.
- R7: The sequence of inserted bits is not all zeros and obeys b[k] = b[k-14] XOR b[k-15]. The generator advances only on bits it inserts, so the sequence runs on without a break across unselected bits and mode changes.
- R8: `in_sync` rises only after 32 consecutive checked bits that each match the XOR of the checked bits 14 and 15 places earlier.
- R9: While in sync, the sixth mismatch within an aligned block of 64 checked bits drops `in_sync`.
- R10: Each mismatching checked bit adds one to `err_cnt`, but only while `in_sync` is high. One corrupted bit in an in-sync loop therefore adds 3.
- R11: `err_cnt` saturates at its all-ones value (parameter `CNT_W`, default 16 bits).
- R12: An `err_clr` pulse zeroes `err_cnt` on the next edge, and it takes priority over an error counted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | High with bit 0 of timeslot 0 |
| mode | input | 2 | 00 off, 01 unframed, 10 8-bit, 11 7-bit |
| dir | input | 1 | 0: generate on transmit, check receive; 1: the reverse |
| ts_mask | input | 32 | Per-timeslot select, bit n for timeslot n |
| err_clr | input | 1 | Clears the error counter |
| tx_in | input | 1 | Transmit-path serial data in |
| tx_out | output | 1 | Transmit-path serial data out |
| rx_in | input | 1 | Receive-path serial data in |
| rx_out | output | 1 | Receive-path serial data out |
| in_sync | output | 1 | Detector locked to the pattern |
| err_cnt | output | 16 | Saturating error count while locked |

## Verification
A counted bit error and a clear pulse can fall on the same edge. The bench provokes this by corrupting a looped-back bit in the cycle where `err_clr` is high. It expects the counter to read zero after that edge, and then to reach exactly 2 once the two echo mismatches of that corrupted bit arrive. A second collision occurs when a realigning `frame_sync` lands mid-frame while the detector is locked. Here lock must hold and no error may be counted.

// File: rtl/prbs_ts_pkg.sv
package prbs_ts_pkg;
    localparam int LFSR_W = 15;
    localparam int TAP_A  = 14;
    localparam int TAP_B  = 13;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_UNFR = 2'b01,
        MODE_OCT  = 2'b10,
        MODE_SEPT = 2'b11
    } prbs_mode_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_HUNT = 2'b01,
        ST_LOCK = 2'b10
    } det_state_e;
endpackage

// File: rtl/prbs_slot_sel.sv
module prbs_slot_sel
    import prbs_ts_pkg::*;
#(
    parameter int NUM_TS  = 32,
    parameter int TS_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  prbs_mode_e        mode,
    input  logic [NUM_TS-1:0] ts_mask,
    output logic              sel
);
    localparam int FRAME_BITS = NUM_TS * TS_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int BIT_W      = $clog2(TS_BITS);
    localparam int TSI_W      = $clog2(NUM_TS);

    logic [POS_W-1:0] pos_q, pos_cur;
    logic [TSI_W-1:0] ts_idx;
    logic [BIT_W-1:0] bit_idx;

    // position of the bit on the wires this cycle; TS_BITS is a power of two
    assign pos_cur = frame_sync ? '0 : pos_q;
    assign ts_idx  = TSI_W'(pos_cur >> BIT_W);
    assign bit_idx = pos_cur[BIT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else if (pos_cur == POS_W'(FRAME_BITS - 1))
            pos_q <= '0;
        else
            pos_q <= pos_cur + 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_OFF:  sel = 1'b0;
            MODE_UNFR: sel = 1'b1;
            MODE_OCT:  sel = ts_mask[ts_idx];
            MODE_SEPT: sel = ts_mask[ts_idx] && (bit_idx != BIT_W'(TS_BITS - 1));
            default:   sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_ts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic pat_bit
);
    logic [LFSR_W-1:0] lfsr_q;

    assign pat_bit = lfsr_q[TAP_A] ^ lfsr_q[TAP_B];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lfsr_q <= '1;
        else if (adv)
            lfsr_q <= {lfsr_q[LFSR_W-2:0], pat_bit};
    end
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_ts_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_RUN  = 32,
    parameter int LOSS_ERRS = 6,
    parameter int LOSS_WIN  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             chk,
    input  logic             din,
    input  logic             err_clr,
    output logic             in_sync,
    output logic [CNT_W-1:0] err_cnt
);
    localparam int RUN_W = $clog2(SYNC_RUN + 1);
    localparam int WIN_W = $clog2(LOSS_WIN);
    localparam int WE_W  = $clog2(LOSS_ERRS + 1);

    det_state_e        state_q, state_nx;
    logic [LFSR_W-1:0] hist_q;
    logic [RUN_W-1:0]  run_q;
    logic [WIN_W-1:0]  win_q;
    logic [WE_W-1:0]   werr_q;
    logic              mis;

    // prediction from the checked history
    assign mis = (hist_q[TAP_A] ^ hist_q[TAP_B]) != din;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    // transitions: OFF->HUNT on enable, HUNT->LOCK on run, LOCK->HUNT on loss, any->OFF
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_nx = ST_HUNT;
            ST_HUNT: begin
                if (!enable)
                    state_nx = ST_OFF;
                else if (chk && !mis && run_q == RUN_W'(SYNC_RUN - 1))
                    state_nx = ST_LOCK;
            end
            ST_LOCK: begin
                if (!enable)
                    state_nx = ST_OFF;
                else if (chk && mis && werr_q == WE_W'(LOSS_ERRS - 1))
                    state_nx = ST_HUNT;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs and per-state counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= '0;
            run_q   <= '0;
            win_q   <= '0;
            werr_q  <= '0;
            err_cnt <= '0;
        end else begin
            if (chk)
                hist_q <= {hist_q[LFSR_W-2:0], din};

            if (state_q != ST_HUNT)
                run_q <= '0;
            else if (chk)
                run_q <= mis ? '0 : run_q + 1'b1;

            if (state_q != ST_LOCK) begin
                win_q  <= '0;
                werr_q <= '0;
            end else if (chk) begin
                if (win_q == WIN_W'(LOSS_WIN - 1)) begin
                    win_q  <= '0;
                    werr_q <= '0;
                end else begin
                    win_q  <= win_q + 1'b1;
                    werr_q <= werr_q + WE_W'(mis);
                end
            end

            if (err_clr)
                err_cnt <= '0;
            else if (state_q == ST_LOCK && chk && mis && err_cnt != '1)
                err_cnt <= err_cnt + 1'b1;
        end
    end

    assign in_sync = (state_q == ST_LOCK);
endmodule

// File: rtl/prbs_ts_engine.sv
module prbs_ts_engine
    import prbs_ts_pkg::*;
#(
    parameter int NUM_TS  = 32,
    parameter int TS_BITS = 8,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [1:0]        mode,
    input  logic              dir,
    input  logic [NUM_TS-1:0] ts_mask,
    input  logic              err_clr,
    input  logic              tx_in,
    output logic              tx_out,
    input  logic              rx_in,
    output logic              rx_out,
    output logic              in_sync,
    output logic [CNT_W-1:0]  err_cnt
);
    prbs_mode_e mode_e;
    logic       sel, pat_bit, chk_din, active;

    assign mode_e = prbs_mode_e'(mode);
    assign active = (mode_e != MODE_OFF);

    prbs_slot_sel #(.NUM_TS(NUM_TS), .TS_BITS(TS_BITS)) slot_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .mode(mode_e), .ts_mask(ts_mask), .sel(sel)
    );

    prbs_gen gen_i (
        .clk(clk), .rst_n(rst_n), .adv(sel), .pat_bit(pat_bit)
    );

    assign tx_out  = (!dir && sel) ? pat_bit : tx_in;
    assign rx_out  = ( dir && sel) ? pat_bit : rx_in;
    assign chk_din = dir ? tx_in : rx_in;

    prbs_chk #(.CNT_W(CNT_W)) chk_i (
        .clk(clk), .rst_n(rst_n), .enable(active), .chk(sel),
        .din(chk_din), .err_clr(err_clr),
        .in_sync(in_sync), .err_cnt(err_cnt)
    );
endmodule

// File: rtl/prbs_ts_engine_chk.sv
module prbs_ts_engine_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             dir,
    input logic             err_clr,
    input logic             tx_in,
    input logic             tx_out,
    input logic             rx_in,
    input logic             rx_out,
    input logic             in_sync,
    input logic [CNT_W-1:0] err_cnt
);
    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |-> (tx_out == tx_in && rx_out == rx_in)); // R1

    AST_OFF_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |=> !in_sync); // R1

    AST_DIR0_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> rx_out == rx_in); // R2

    AST_DIR1_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> tx_out == tx_in); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (err_cnt == $past(err_cnt) ||
                      err_cnt == CNT_W'($past(err_cnt) + 1'b1))); // R10

    AST_CNT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !err_clr) |=> $stable(err_cnt)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == {CNT_W{1'b1}} && !err_clr) |=> err_cnt == {CNT_W{1'b1}}); // R11

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> err_cnt == '0); // R12
endmodule

bind prbs_ts_engine prbs_ts_engine_chk #(.CNT_W(CNT_W)) sva_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir(dir), .err_clr(err_clr),
    .tx_in(tx_in), .tx_out(tx_out), .rx_in(rx_in), .rx_out(rx_out),
    .in_sync(in_sync), .err_cnt(err_cnt)
);

// File: tb/prbs_ts_engine_tb_top.sv
module prbs_ts_engine_tb_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          dir = 1'b0;
    logic [31:0]   mask = '0;
    logic          err_clr = 1'b0;
    logic          tx_in = 1'b0;
    logic          rx_in = 1'b0;
    logic          tx_out, rx_out, in_sync;
    logic [CW-1:0] err_cnt;

    int checks = 0;
    int fails = 0;
    int pos = 0;
    bit seq [0:4095];
    int nseq, rec_err, pass_err, ones;

    always #10 clk = ~clk;

    prbs_ts_engine #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mode(mode),
        .dir(dir), .ts_mask(mask), .err_clr(err_clr), .tx_in(tx_in),
        .tx_out(tx_out), .rx_in(rx_in), .rx_out(rx_out),
        .in_sync(in_sync), .err_cnt(err_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_phase();
        nseq = 0; rec_err = 0; pass_err = 0; ones = 0;
    endtask

    function automatic bit exp_sel(input int p);
        case (mode)
            2'b01:   return 1'b1;
            2'b10:   return mask[p / 8];
            2'b11:   return mask[p / 8] && (p % 8 != 7);
            default: return 1'b0;
        endcase
    endfunction

    // one serial bit: drive, loop the generated path back with optional corruption
    task automatic step(input bit inj, input bit clr);
        bit gen_b, src_b, other_ok;
        @(negedge clk);
        frame_sync = (pos == 0);
        err_clr    = clr;
        if (!dir) begin
            tx_in = (pos % 3 == 0);
            rx_in = 1'b0;
            #1;
            gen_b = tx_out;
            src_b = tx_in;
            rx_in = tx_out ^ inj;
            #1;
            other_ok = (rx_out == rx_in);
        end else begin
            rx_in = (pos % 5 == 1);
            tx_in = 1'b0;
            #1;
            gen_b = rx_out;
            src_b = rx_in;
            tx_in = rx_out ^ inj;
            #1;
            other_ok = (tx_out == tx_in);
        end
        if (exp_sel(pos)) begin
            if (nseq < 4096) begin
                seq[nseq] = gen_b;
                if (nseq >= 15 && seq[nseq] != (seq[nseq-14] ^ seq[nseq-15]))
                    rec_err++;
                nseq++;
            end
            if (gen_b) ones++;
        end else if (gen_b != src_b) begin
            pass_err++;
        end
        if (!other_ok) pass_err++;
        pos = (pos + 1) % 256;
        @(posedge clk);
        #2;
        err_clr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin
        #35 rst_n = 1'b1;
        #5;
        check("R1 reset in_sync", in_sync, 0);
        check("R1 reset err_cnt", err_cnt, 0);

        // mode off: pass-through
        begin_phase();
        run(256);
        check("R1 off pass-through", pass_err, 0);
        check("R1 off in_sync", in_sync, 0);

        // unframed, mask ignored (all zero)
        mode = 2'b01; mask = '0; begin_phase();
        run(31);
        check("R8 no sync before 32 bits", in_sync, 0);
        run(993);
        check("R4 unframed every bit replaced", pass_err, 0);
        check("R7 recurrence unframed", rec_err, 0);
        check("R7 pattern nonzero", (ones > 0), 1);
        check("R8 sync reached", in_sync, 1);
        check("R10 clean loop no errors", err_cnt, 0);

        // single corrupted bit gives three mismatches
        step(1'b0, 1'b1); run(10); step(1'b1, 1'b0); run(30);
        check("R10 one injection counts 3", err_cnt, 3);
        check("R10 still in sync", in_sync, 1);

        // clear and counted error on the same edge
        step(1'b1, 1'b1);
        check("R12 clear wins over error", err_cnt, 0);
        run(20);
        check("R12 echo errors after clear", err_cnt, 2);

        // saturation with 4-bit counter
        step(1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b0);
            run(99);
        end
        check("R11 saturates", err_cnt, 15);
        check("R11 sync held", in_sync, 1);

        // loss of sync
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 1'b0); run(2);
        end
        check("R9 loss of sync", in_sync, 0);
        run(150);
        check("R8 resync after clean run", in_sync, 1);

        // 8-bit mode with realignment mid-frame
        mode = 2'b10; mask = 32'h0000_F00F; begin_phase();
        step(1'b0, 1'b1);
        run(799);
        pos = 0;
        run(800);
        check("R5 unselected slots pass", pass_err, 0);
        check("R7 recurrence 8-bit", rec_err, 0);
        check("R3 realigned frame no errors", err_cnt, 0);
        check("R3 lock held across realign", in_sync, 1);

        // 7-bit mode
        mode = 2'b11; mask = 32'h8000_0101; begin_phase();
        step(1'b0, 1'b1);
        run(1535);
        check("R6 lsb passes through", pass_err, 0);
        check("R7 recurrence 7-bit", rec_err, 0);
        check("R6 lsb not checked", err_cnt, 0);
        check("R6 sync in 7-bit", in_sync, 1);

        // reversed direction
        dir = 1'b1; mode = 2'b01; begin_phase();
        step(1'b0, 1'b1);
        run(599);
        check("R2 reversed paths", pass_err, 0);
        check("R7 recurrence reversed", rec_err, 0);
        check("R2 sync on transmit input", in_sync, 1);
        check("R2 no errors reversed", err_cnt, 0);

        // back to off
        mode = 2'b00; begin_phase();
        run(5);
        check("R1 off drops sync", in_sync, 0);
        check("R1 off pass-through again", pass_err, 0);

        report();
    end
endmodule